// File: doc/BRIEF.md
# Per-Thread Fetch Status Controller

This block holds one fetch status register per hardware thread of a multithreaded instruction front end. On every clock edge it folds in the block and unblock pulses from four downstream stages, squash requests from the commit and decode stages, a reorder-buffer "still squashing" indication, a global context-switch stall, and instruction-cache fill returns tagged with a request identifier. These events are resolved per thread in a fixed priority, and the result is a new status for each thread.

Each thread also keeps a redirect PC and the following sequential PC, which are loaded by squashes. A stage-level activity flag is the OR, over the threads marked active, of "thread can make progress", which means it is running, squashing or has a completed miss. One-cycle activate and deactivate pulses are raised only when that flag changes. A shared counter records every fill return that was thrown away.

Top module: `fetch_status_ctl`

## Requirements
- R1: While reset is held and after it is released, every thread reports status Running (code 0), redirect PC 0 and next PC equal to the instruction size (4). The stage flag, both pulses and the dropped-fill counter read 0.
- R2: Each thread has a sticky stall flag for each of four stages. The set/clear bit for stage s and thread t is s*T+t, with s = 0 decode, 1 rename, 2 execute and 3 commit. A set pulse raises the flag and a clear pulse lowers it. The thread reports Blocked (code 3) while any of its flags is raised and returns to Running when the last flag is cleared. Set and clear are never asserted together on the same bit.
- R3: A commit squash for a thread wins over every other event in that cycle. The thread enters Squashing (code 2), loads the commit redirect PC, sets next PC to that PC plus 4, and drops its outstanding miss.
- R4: When there is no commit squash and the reorder buffer reports that it is still squashing, the thread is held in Squashing even if stall flags are raised. A thread in Squashing with no new squash and no stall returns to Running.
- R5: A decode squash loads the decode redirect PC and enters Squashing only if the thread is not already in Squashing. Otherwise the PC is left unchanged.
- R6: A thread that is not waiting on a miss (code 4) moves to Blocked when any of its stall flags or the global context-switch input is set. A thread that is waiting on a miss stays in the miss wait.
- R7: A fill return for a thread in miss wait whose tag matches the recorded request tag moves that thread to Blocked if a stall is pending, and otherwise to Miss Complete (code 5).
- R8: A fill return is discarded when the thread is not in miss wait, when the tag differs, or when a higher-priority event takes the thread in that cycle. Each discarded return adds 1 to the dropped-fill counter and leaves the thread's status as it would have been without the return.
- R9: The stage flag is 1 when at least one thread in the active mask is in Running, Squashing or Miss Complete. An activate pulse marks the cycle in which the flag rises and a deactivate pulse marks the cycle in which it falls. The two pulses never occur together.
- R10: A Running thread given a miss start enters miss wait and records its request tag. A Miss Complete thread given a fetch acknowledge returns to Running.
- R11: A Running thread given a trap request enters Trap Pending (code 6), and given a quiesce request enters Quiesce Pending (code 7). It stays in that state while no other event arrives, and a commit squash moves it to Squashing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| thr_active | input | T | Mask of threads counted for the stage flag |
| ctx_switch | input | 1 | Global context-switch stall |
| stall_set | input | 4*T | Stage block pulses, bit s*T+t |
| stall_clr | input | 4*T | Stage unblock pulses, bit s*T+t |
| cmt_squash | input | T | Commit squash per thread |
| cmt_redirect | input | T*PCW | Commit redirect PC per thread |
| rob_squashing | input | T | Reorder buffer still squashing, per thread |
| dec_squash | input | T | Decode squash per thread |
| dec_redirect | input | T*PCW | Decode redirect PC per thread |
| miss_start | input | T | Thread begins an instruction-cache miss |
| miss_tag | input | T*IDW | Request tag of the miss being started |
| fetch_ack | input | T | Fetch consumed a completed miss |
| trap_req | input | T | Park thread awaiting trap handling |
| quiesce_req | input | T | Park thread awaiting wake-up |
| fill_vld | input | 1 | Cache fill return valid |
| fill_tid | input | TIDW | Thread of the fill return |
| fill_tag | input | IDW | Request tag of the fill return |
| thr_status | output | 3*T | Status code per thread |
| redirect_pc | output | T*PCW | Current fetch PC per thread |
| next_pc | output | T*PCW | Sequential PC per thread |
| stage_active | output | 1 | Stage-level activity flag |
| stage_act_pulse | output | 1 | Activity flag rose |
| stage_deact_pulse | output | 1 | Activity flag fell |
| fill_drop_cnt | output | CNTW | Count of discarded fill returns |

## Verification
The key collision happens when a fill return arrives for a thread in the same cycle as a commit squash, a decode squash and a new stall on that same thread. The bench starts a miss on a thread and then, in one cycle, presents all four events together with the matching tag. It expects Squashing with the commit PC, a decode PC that is ignored, and the dropped-fill counter advanced by one. A second overlap is checked as well: a matching fill arriving while a stall flag is held must land in Blocked rather than Miss Complete.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_IDLE  = 3'd1,
    ST_SQSH  = 3'd2,
    ST_BLKD  = 3'd3,
    ST_MWAIT = 3'd4,
    ST_MDONE = 3'd5,
    ST_TRAP  = 3'd6,
    ST_QUIES = 3'd7
  } fst_e;

  localparam int unsigned NSTG = 4;

  function automatic logic fst_live(input fst_e s);
    return (s == ST_RUN) || (s == ST_SQSH) || (s == ST_MDONE);
  endfunction

endpackage

// File: rtl/fsc_stall_flags.sv
module fsc_stall_flags #(
  parameter int unsigned NS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NS-1:0] set_i,
  input  logic [NS-1:0] clr_i,
  output logic          any_d
);
  logic [NS-1:0] flag_q, flag_d;

  always_comb begin
    flag_d = (flag_q | set_i) & ~clr_i;
    any_d  = |flag_d;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_d;
  end
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
  import fsc_pkg::*;
#(
  parameter int unsigned PCW = 32,
  parameter int unsigned IDW = 4,
  parameter int unsigned ISZ = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           stall_any,
  input  logic           ctx_sw,
  input  logic           cmt_sq,
  input  logic [PCW-1:0] cmt_pc,
  input  logic           rob_sq,
  input  logic           dec_sq,
  input  logic [PCW-1:0] dec_pc,
  input  logic           fill_hit,
  input  logic [IDW-1:0] fill_tag,
  input  logic           miss_go,
  input  logic [IDW-1:0] miss_tag,
  input  logic           ack,
  input  logic           trap_go,
  input  logic           quies_go,
  output fst_e           st_q,
  output fst_e           st_d,
  output logic [PCW-1:0] pc_q,
  output logic [PCW-1:0] npc_q,
  output logic           fill_drop
);
  localparam logic [PCW-1:0] STEP = PCW'(ISZ);

  logic [PCW-1:0] pc_d, npc_d;
  logic [IDW-1:0] tag_q, tag_d;
  logic           pend_q, pend_d;
  logic           take;
  logic           held;

  always_comb begin
    st_d   = st_q;
    pc_d   = pc_q;
    npc_d  = npc_q;
    tag_d  = tag_q;
    pend_d = pend_q;
    take   = 1'b0;
    held   = stall_any | ctx_sw;
    if (cmt_sq) begin
      st_d   = ST_SQSH;
      pc_d   = cmt_pc;
      npc_d  = cmt_pc + STEP;
      pend_d = 1'b0;
    end else if (rob_sq) begin
      st_d = ST_SQSH;
    end else if (dec_sq && st_q != ST_SQSH) begin
      st_d   = ST_SQSH;
      pc_d   = dec_pc;
      npc_d  = dec_pc + STEP;
      pend_d = 1'b0;
    end else if (st_q != ST_MWAIT && held) begin
      st_d = ST_BLKD;
    end else if (st_q == ST_BLKD || st_q == ST_SQSH) begin
      st_d = ST_RUN;
    end else begin
      unique case (st_q)
        ST_MWAIT: begin
          if (fill_hit && pend_q && fill_tag == tag_q) begin
            take   = 1'b1;
            pend_d = 1'b0;
            st_d   = held ? ST_BLKD : ST_MDONE;
          end
        end
        ST_MDONE: if (ack) st_d = ST_RUN;
        ST_RUN: begin
          if (miss_go) begin
            st_d   = ST_MWAIT;
            tag_d  = miss_tag;
            pend_d = 1'b1;
          end else if (trap_go) begin
            st_d = ST_TRAP;
          end else if (quies_go) begin
            st_d = ST_QUIES;
          end
        end
        default: ;
      endcase
    end
    fill_drop = fill_hit & ~take;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_RUN;
      pc_q   <= '0;
      npc_q  <= STEP;
      tag_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      pc_q   <= pc_d;
      npc_q  <= npc_d;
      tag_q  <= tag_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/fsc_activity.sv
module fsc_activity #(
  parameter int unsigned T = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [T-1:0] live_d,
  input  logic [T-1:0] mask,
  output logic         act_q,
  output logic         up_q,
  output logic         dn_q
);
  logic act_d;
  assign act_d = |(live_d & mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q <= 1'b0;
      up_q  <= 1'b0;
      dn_q  <= 1'b0;
    end else begin
      act_q <= act_d;
      up_q  <= act_d & ~act_q;
      dn_q  <= ~act_d & act_q;
    end
  end
endmodule

// File: rtl/fetch_status_ctl.sv
module fetch_status_ctl
  import fsc_pkg::*;
#(
  parameter int unsigned T    = 4,
  parameter int unsigned PCW  = 32,
  parameter int unsigned IDW  = 4,
  parameter int unsigned ISZ  = 4,
  parameter int unsigned CNTW = 8,
  localparam int unsigned TIDW = (T > 1) ? $clog2(T) : 1,
  localparam int unsigned NSB  = NSTG * T
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [T-1:0]      thr_active,
  input  logic              ctx_switch,
  input  logic [NSB-1:0]    stall_set,
  input  logic [NSB-1:0]    stall_clr,
  input  logic [T-1:0]      cmt_squash,
  input  logic [T*PCW-1:0]  cmt_redirect,
  input  logic [T-1:0]      rob_squashing,
  input  logic [T-1:0]      dec_squash,
  input  logic [T*PCW-1:0]  dec_redirect,
  input  logic [T-1:0]      miss_start,
  input  logic [T*IDW-1:0]  miss_tag,
  input  logic [T-1:0]      fetch_ack,
  input  logic [T-1:0]      trap_req,
  input  logic [T-1:0]      quiesce_req,
  input  logic              fill_vld,
  input  logic [TIDW-1:0]   fill_tid,
  input  logic [IDW-1:0]    fill_tag,
  output logic [3*T-1:0]    thr_status,
  output logic [T*PCW-1:0]  redirect_pc,
  output logic [T*PCW-1:0]  next_pc,
  output logic              stage_active,
  output logic              stage_act_pulse,
  output logic              stage_deact_pulse,
  output logic [CNTW-1:0]   fill_drop_cnt
);
  logic [T-1:0]    live_d;
  logic [T-1:0]    drop_v;
  logic [CNTW-1:0] cnt_q;

  for (genvar t = 0; t < T; t++) begin : g_thr
    logic [NSTG-1:0] set_t, clr_t;
    logic            any_t;
    logic            hit_t;
    fst_e            st_q_t, st_d_t;

    for (genvar s = 0; s < NSTG; s++) begin : g_stg
      assign set_t[s] = stall_set[s*T+t];
      assign clr_t[s] = stall_clr[s*T+t];
    end

    assign hit_t = fill_vld && (fill_tid == TIDW'(t));

    fsc_stall_flags #(.NS(NSTG)) u_flags (
      .clk(clk), .rst(rst), .set_i(set_t), .clr_i(clr_t), .any_d(any_t)
    );

    fsc_thread_fsm #(.PCW(PCW), .IDW(IDW), .ISZ(ISZ)) u_fsm (
      .clk      (clk),
      .rst      (rst),
      .stall_any(any_t),
      .ctx_sw   (ctx_switch),
      .cmt_sq   (cmt_squash[t]),
      .cmt_pc   (cmt_redirect[t*PCW +: PCW]),
      .rob_sq   (rob_squashing[t]),
      .dec_sq   (dec_squash[t]),
      .dec_pc   (dec_redirect[t*PCW +: PCW]),
      .fill_hit (hit_t),
      .fill_tag (fill_tag),
      .miss_go  (miss_start[t]),
      .miss_tag (miss_tag[t*IDW +: IDW]),
      .ack      (fetch_ack[t]),
      .trap_go  (trap_req[t]),
      .quies_go (quiesce_req[t]),
      .st_q     (st_q_t),
      .st_d     (st_d_t),
      .pc_q     (redirect_pc[t*PCW +: PCW]),
      .npc_q    (next_pc[t*PCW +: PCW]),
      .fill_drop(drop_v[t])
    );

    assign thr_status[t*3 +: 3] = st_q_t;
    assign live_d[t]            = fst_live(st_d_t);
  end

  fsc_activity #(.T(T)) u_act (
    .clk(clk), .rst(rst), .live_d(live_d), .mask(thr_active),
    .act_q(stage_active), .up_q(stage_act_pulse), .dn_q(stage_deact_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (|drop_v) cnt_q <= cnt_q + 1'b1;
  end
  assign fill_drop_cnt = cnt_q;
endmodule

// File: rtl/fetch_status_ctl_chk.sv
module fetch_status_ctl_chk #(
  parameter int unsigned T    = 4,
  parameter int unsigned PCW  = 32,
  parameter int unsigned ISZ  = 4,
  parameter int unsigned CNTW = 8,
  parameter int unsigned TIDW = 2,
  parameter int unsigned NSB  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [NSB-1:0]   stall_set,
  input logic [NSB-1:0]   stall_clr,
  input logic [T-1:0]     cmt_squash,
  input logic [T*PCW-1:0] cmt_redirect,
  input logic [T-1:0]     rob_squashing,
  input logic             fill_vld,
  input logic [TIDW-1:0]  fill_tid,
  input logic [3*T-1:0]   thr_status,
  input logic [T*PCW-1:0] redirect_pc,
  input logic [T*PCW-1:0] next_pc,
  input logic             stage_active,
  input logic             stage_act_pulse,
  input logic             stage_deact_pulse,
  input logic [CNTW-1:0]  fill_drop_cnt
);
  p_set_clr_excl_r2: assert property (@(posedge clk) disable iff (rst)
    (stall_set & stall_clr) == '0);

  for (genvar t = 0; t < T; t++) begin : g_t
    p_cmt_squash_r3: assert property (@(posedge clk) disable iff (rst)
      cmt_squash[t] |=> (thr_status[t*3 +: 3] == 3'd2) &&
                        (redirect_pc[t*PCW +: PCW] == $past(cmt_redirect[t*PCW +: PCW])));
    p_cmt_npc_r3: assert property (@(posedge clk) disable iff (rst)
      cmt_squash[t] |=> next_pc[t*PCW +: PCW] == redirect_pc[t*PCW +: PCW] + PCW'(ISZ));
    p_rob_hold_r4: assert property (@(posedge clk) disable iff (rst)
      rob_squashing[t] |=> thr_status[t*3 +: 3] == 3'd2);
  end

  p_drop_count_r8: assert property (@(posedge clk) disable iff (rst)
    (fill_vld && thr_status[fill_tid*3 +: 3] != 3'd4) |=>
      fill_drop_cnt == CNTW'($past(fill_drop_cnt) + 1'b1));
  p_rise_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    stage_act_pulse |-> (stage_active && !$past(stage_active)));
  p_fall_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    stage_deact_pulse |-> (!stage_active && $past(stage_active)));
  p_pulse_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(stage_act_pulse && stage_deact_pulse));
endmodule

bind fetch_status_ctl fetch_status_ctl_chk #(
  .T(T), .PCW(PCW), .ISZ(ISZ), .CNTW(CNTW), .TIDW(TIDW), .NSB(NSB)
) u_chk (
  .clk(clk), .rst(rst), .stall_set(stall_set), .stall_clr(stall_clr),
  .cmt_squash(cmt_squash), .cmt_redirect(cmt_redirect),
  .rob_squashing(rob_squashing), .fill_vld(fill_vld), .fill_tid(fill_tid),
  .thr_status(thr_status), .redirect_pc(redirect_pc), .next_pc(next_pc),
  .stage_active(stage_active), .stage_act_pulse(stage_act_pulse),
  .stage_deact_pulse(stage_deact_pulse), .fill_drop_cnt(fill_drop_cnt)
);

// File: tb/sim_fetch_status_ctl.sv
`timescale 1ns/1ps
module sim_fetch_status_ctl;
  localparam int T = 4, PCW = 32, IDW = 4, CNTW = 8, TIDW = 2, NSB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [T-1:0] thr_active, cmt_squash, rob_squashing, dec_squash;
  logic [T-1:0] miss_start, fetch_ack, trap_req, quiesce_req;
  logic ctx_switch, fill_vld;
  logic [NSB-1:0] stall_set, stall_clr;
  logic [T*PCW-1:0] cmt_redirect, dec_redirect;
  logic [T*IDW-1:0] miss_tag;
  logic [TIDW-1:0] fill_tid;
  logic [IDW-1:0] fill_tag;
  logic [3*T-1:0] thr_status;
  logic [T*PCW-1:0] redirect_pc, next_pc;
  logic stage_active, stage_act_pulse, stage_deact_pulse;
  logic [CNTW-1:0] fill_drop_cnt;

  fetch_status_ctl #(.T(T), .PCW(PCW), .IDW(IDW), .ISZ(4), .CNTW(CNTW)) u0 (
    .clk(clk), .rst(rst), .thr_active(thr_active), .ctx_switch(ctx_switch),
    .stall_set(stall_set), .stall_clr(stall_clr), .cmt_squash(cmt_squash),
    .cmt_redirect(cmt_redirect), .rob_squashing(rob_squashing),
    .dec_squash(dec_squash), .dec_redirect(dec_redirect),
    .miss_start(miss_start), .miss_tag(miss_tag), .fetch_ack(fetch_ack),
    .trap_req(trap_req), .quiesce_req(quiesce_req), .fill_vld(fill_vld),
    .fill_tid(fill_tid), .fill_tag(fill_tag), .thr_status(thr_status),
    .redirect_pc(redirect_pc), .next_pc(next_pc), .stage_active(stage_active),
    .stage_act_pulse(stage_act_pulse), .stage_deact_pulse(stage_deact_pulse),
    .fill_drop_cnt(fill_drop_cnt)
  );

  // kinds: 0 status, 1 pc, 2 next pc, 3 stage flag, 4 rise, 5 fall, 6 drop count
  typedef struct {
    int          kind;
    int          tid;
    logic [31:0] val;
    string       req;
  } exp_t;
  exp_t q[$];

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  function automatic logic [31:0] observe(int kind, int tid);
    case (kind)
      0: return 32'(thr_status[tid*3 +: 3]);
      1: return redirect_pc[tid*PCW +: PCW];
      2: return next_pc[tid*PCW +: PCW];
      3: return 32'(stage_active);
      4: return 32'(stage_act_pulse);
      5: return 32'(stage_deact_pulse);
      default: return 32'(fill_drop_cnt);
    endcase
  endfunction

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        logic [31:0] got;
        e   = q.pop_front();
        got = observe(e.kind, e.tid);
        total++;
        if (got !== e.val) begin
          bad++;
          $display("FAIL %s kind=%0d thread=%0d actual=%0h expected=%0h",
                   e.req, e.kind, e.tid, got, e.val);
        end
      end
    end
  end

  task automatic expect_v(int kind, int tid, logic [31:0] v, string req);
    exp_t e;
    e.kind = kind; e.tid = tid; e.val = v; e.req = req;
    q.push_back(e);
  endtask

  task automatic quiet();
    ctx_switch = 0; stall_set = '0; stall_clr = '0; cmt_squash = '0;
    rob_squashing = '0; dec_squash = '0; miss_start = '0; fetch_ack = '0;
    trap_req = '0; quiesce_req = '0; fill_vld = 0; fill_tid = '0; fill_tag = '0;
  endtask

  task automatic prep();
    @(negedge clk);
    quiet();
  endtask

  task automatic fire();
    @(posedge clk);
  endtask

  function automatic int sb(int stg, int t);
    return stg * T + t;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    thr_active = '0; cmt_redirect = '0; dec_redirect = '0; miss_tag = '0;
    quiet();
    repeat (2) fire();
    // R1 reset values
    for (int t = 0; t < T; t++) begin
      expect_v(0, t, 0, "R1");
      expect_v(1, t, 0, "R1");
      expect_v(2, t, 4, "R1");
    end
    expect_v(3, 0, 0, "R1");
    expect_v(6, 0, 0, "R1");
    prep(); rst = 0; thr_active = 4'b1111; fire();
    expect_v(3, 0, 1, "R9"); expect_v(4, 0, 1, "R9");
    prep(); fire();
    expect_v(4, 0, 0, "R9"); expect_v(3, 0, 1, "R9");
    // R2 sticky stall flags on thread 1
    prep(); stall_set[sb(0,1)] = 1; fire();
    expect_v(0, 1, 3, "R2"); expect_v(0, 0, 0, "R2");
    prep(); stall_set[sb(1,1)] = 1; fire();
    expect_v(0, 1, 3, "R2");
    prep(); stall_clr[sb(0,1)] = 1; fire();
    expect_v(0, 1, 3, "R2");
    prep(); stall_clr[sb(1,1)] = 1; fire();
    expect_v(0, 1, 0, "R2");
    // R6 context switch blocks all
    prep(); ctx_switch = 1; fire();
    expect_v(0, 0, 3, "R6"); expect_v(0, 3, 3, "R6");
    expect_v(3, 0, 0, "R9"); expect_v(5, 0, 1, "R9");
    prep(); fire();
    expect_v(0, 0, 0, "R6"); expect_v(4, 0, 1, "R9");
    // R10 miss start on thread 2
    prep(); miss_start[2] = 1; miss_tag[2*IDW +: IDW] = 4'd5; fire();
    expect_v(0, 2, 4, "R10");
    prep(); stall_set[sb(2,2)] = 1; fire();
    expect_v(0, 2, 4, "R6");
    prep(); fill_vld = 1; fill_tid = 2; fill_tag = 4'd6; fire();
    expect_v(0, 2, 4, "R8"); expect_v(6, 0, 1, "R8");
    prep(); fill_vld = 1; fill_tid = 2; fill_tag = 4'd5; fire();
    expect_v(0, 2, 3, "R7"); expect_v(6, 0, 1, "R7");
    prep(); stall_clr[sb(2,2)] = 1; fire();
    expect_v(0, 2, 0, "R2");
    prep(); miss_start[2] = 1; miss_tag[2*IDW +: IDW] = 4'd9; fire();
    expect_v(0, 2, 4, "R10");
    prep(); fill_vld = 1; fill_tid = 2; fill_tag = 4'd9; fire();
    expect_v(0, 2, 5, "R7");
    prep(); fetch_ack[2] = 1; fire();
    expect_v(0, 2, 0, "R10");
    prep(); fill_vld = 1; fill_tid = 3; fill_tag = 4'd0; fire();
    expect_v(0, 3, 0, "R8"); expect_v(6, 0, 2, "R8");
    // R3 collision on thread 0
    prep(); miss_start[0] = 1; miss_tag[0 +: IDW] = 4'd3; fire();
    expect_v(0, 0, 4, "R10");
    prep();
    cmt_squash[0] = 1; cmt_redirect[0 +: PCW] = 32'h1000;
    dec_squash[0] = 1; dec_redirect[0 +: PCW] = 32'h2000;
    stall_set[sb(0,0)] = 1;
    fill_vld = 1; fill_tid = 0; fill_tag = 4'd3;
    fire();
    expect_v(0, 0, 2, "R3"); expect_v(1, 0, 32'h1000, "R3");
    expect_v(2, 0, 32'h1004, "R3"); expect_v(6, 0, 3, "R8");
    prep(); rob_squashing[0] = 1; fire();
    expect_v(0, 0, 2, "R4");
    prep(); dec_squash[0] = 1; dec_redirect[0 +: PCW] = 32'h3000; fire();
    expect_v(1, 0, 32'h1000, "R5"); expect_v(0, 0, 3, "R5");
    prep(); stall_clr[sb(0,0)] = 1; fire();
    expect_v(0, 0, 0, "R2");
    prep(); dec_squash[0] = 1; dec_redirect[0 +: PCW] = 32'h3000; fire();
    expect_v(0, 0, 2, "R5"); expect_v(1, 0, 32'h3000, "R5");
    expect_v(2, 0, 32'h3004, "R5");
    prep(); fire();
    expect_v(0, 0, 0, "R4");
    // R11 park states
    prep(); trap_req[3] = 1; fire();
    expect_v(0, 3, 6, "R11");
    prep(); fire();
    expect_v(0, 3, 6, "R11");
    prep(); quiesce_req[1] = 1; fire();
    expect_v(0, 1, 7, "R11"); expect_v(0, 3, 6, "R11");
    prep(); cmt_squash[3] = 1; cmt_redirect[3*PCW +: PCW] = 32'h40; fire();
    expect_v(0, 3, 2, "R11"); expect_v(1, 3, 32'h40, "R3");
    // R9 active mask
    prep(); thr_active = 4'b0000; fire();
    expect_v(3, 0, 0, "R9"); expect_v(5, 0, 1, "R9");
    prep(); thr_active = 4'b0010; fire();
    expect_v(3, 0, 0, "R9"); expect_v(4, 0, 0, "R9"); expect_v(5, 0, 0, "R9");
    prep(); thr_active = 4'b0001; fire();
    expect_v(3, 0, 1, "R9"); expect_v(4, 0, 1, "R9");
    prep();
    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule